// File: doc/BRIEF.md
# Half-Duplex Serial Sampling Converter Device Model

This block behaves like the device end of a small half-duplex serial link of the kind used by sampling converters. It is meant to stand in for the converter during loopback testing of a host controller. The host lowers an active-low select line and clocks a serial line. It first sends a start bit and a three-bit configuration word. It then reads back a low null bit, followed by a 12-bit sample that the block takes from a parallel input port. The host may also use one bidirectional wire for both directions. No analog function is modelled.

The three pins from the host are taken into the system clock domain through a synchronizer of `SYNC` flops. Edges of the serial clock are detected there. The data output changes a fixed number of system clocks after each falling serial clock edge. Received bits are taken on rising serial clock edges. If the host keeps clocking after the last MSB-first bit, the block sends the same sample again, least significant end first, and then sends zeros for as long as clocking continues. Raising select aborts the exchange from any point and releases the output.

Top module: `sadc_device_model`

## Requirements
- R1: After reset, and whenever select (`cs_n`) is high, `sdo_oe` is 0 and `sdo` is 0. Both are reached within SYNC+1 system clocks of select rising.
- R2: While select is low and no start bit has arrived, any number of rising serial clock edges with `sdi` low have no effect. `sdo_oe` stays 0 and `cfg_valid` stays 0.
- R3: The first rising edge with `sdi` high is the start bit. The next three rising edges shift `sdi` into `cfg`, and the first of these bits lands in `cfg[2]`. `cfg_valid` goes to 1 on the third of these edges. It is cleared when a new session begins with select falling.
- R4: `sdo_oe` stays 0 while the start bit and the configuration bits are being received.
- R5: On the first falling serial clock edge after the third configuration bit, `sdo_oe` goes to 1 and a null bit of value 0 is driven.
- R6: On the next 12 falling edges, the captured sample is driven MSB first, from bit 11 down to bit 0.
- R7: The sample is captured from `sample` on the rising edge that takes in the third configuration bit. Later changes on `sample` do not alter the readout.
- R8: If clocking goes on after bit 0, the next 11 falling edges drive bits 1 through 11. Every falling edge after that drives 0.
- R9: Select rising at any point aborts the exchange. A following session behaves as a fresh one from R2 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sample | input | 12 | Parallel sample value to be returned |
| sdo | output | 1 | Serial data to the host; valid when `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable; 0 means the line is released (high impedance) |
| cfg | output | 3 | Last configuration word received |
| cfg_valid | output | 1 | A full configuration word arrived in this session |

## Verification
Every pin edge reaches the block's registers SYNC+1 system clocks later, which is three clocks with the default setting. A new `sdo` bit is therefore due three clocks after a falling serial clock edge, and `cfg`, `cfg_valid` and the captured sample are due three clocks after a rising edge. The bench holds each serial clock phase for eight system clocks. It reads `sdo` and `sdo_oe` at the end of the low phase, and reads `cfg` once the high phase that follows the third configuration bit has ended. Every sampling point therefore lies well after the due cycle and before the next pin edge.

// File: rtl/sadc_device_model.sv
module sadc_device_model #(
  parameter int WIDTH    = 12,
  parameter int CFG_BITS = 3,
  parameter int SYNC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic [WIDTH-1:0]    sample,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [CFG_BITS-1:0] cfg,
  output logic                cfg_valid
);
  localparam int IW = $clog2(WIDTH);
  localparam int CW = $clog2(CFG_BITS + 1);

  typedef enum logic [2:0] {IDLE, HUNT, CFGIN, PRE, MSB, LSB, ZERO} st_t;
  st_t st;

  logic [SYNC:0]     cs_p, ck_p;
  logic [SYNC-1:0]   di_p;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [CFG_BITS-1:0] sh;
  logic [WIDTH-1:0]  cap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[SYNC-1:0], cs_n};
      ck_p <= {ck_p[SYNC-1:0], sclk};
      di_p <= {di_p[SYNC-2:0], sdi};
    end

  wire cs_s = cs_p[SYNC-1];
  wire din  = di_p[SYNC-1];
  wire rise = ck_p[SYNC-1] & ~ck_p[SYNC];
  wire fall = ~ck_p[SYNC-1] & ck_p[SYNC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; sdo <= 1'b0; sdo_oe <= 1'b0;
      cfg <= '0; cfg_valid <= 1'b0;
      cnt <= '0; idx <= '0; sh <= '0; cap <= '0;
    end else if (cs_s) begin
      st <= IDLE; sdo <= 1'b0; sdo_oe <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          st <= HUNT;
          cfg_valid <= 1'b0;
        end
        HUNT: if (rise && din) begin
          st  <= CFGIN;
          cnt <= '0;
        end
        CFGIN: if (rise) begin
          sh  <= {sh[CFG_BITS-2:0], din};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CFG_BITS - 1)) begin
            cfg       <= {sh[CFG_BITS-2:0], din};
            cfg_valid <= 1'b1;
            cap       <= sample;
            st        <= PRE;
          end
        end
        PRE: if (fall) begin
          sdo_oe <= 1'b1;
          sdo    <= 1'b0;
          idx    <= IW'(WIDTH - 1);
          st     <= MSB;
        end
        MSB: if (fall) begin
          sdo <= cap[idx];
          if (idx == '0) begin
            idx <= IW'(1);
            st  <= LSB;
          end else idx <= idx - 1'b1;
        end
        LSB: if (fall) begin
          sdo <= cap[idx];
          if (idx == IW'(WIDTH - 1)) st <= ZERO;
          else idx <= idx + 1'b1;
        end
        ZERO: if (fall) sdo <= 1'b0;
        default: st <= IDLE;
      endcase
    end

  // R1 / R9: select high releases the line
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!sdo_oe && !sdo));
  // R5: the output is enabled first with the null bit
  a_r5_null_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);
  // R7: the captured word holds while driving
  a_r7_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe)) |-> $stable(cap));
  // R3: a word completes only inside a session
  a_r3_valid_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(!cs_s));
  // R8: the tail is zeros
  a_r8_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZERO && fall && !cs_s) |=> !sdo);
  // R4: released while hunting or receiving
  a_r4_quiet_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HUNT || st == CFGIN) |-> !sdo_oe);
endmodule

// File: tb/sadc_device_model_test.sv
module sadc_device_model_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, cfg_valid;
  logic [2:0] cfg;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sadc_device_model uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .cfg(cfg), .cfg_valid(cfg_valid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [11:0] w, input int k);
    if (k < 12) return w[11-k];
    if (k < 23) return w[k-11];
    return 1'b0;
  endfunction

  task automatic pulse(input logic d, output logic o, output logic e);
    sclk = 1'b0; sdi = d;
    repeat (HALF) @(negedge clk);
    o = sdo; e = sdo_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic release_cs();
    sclk = 1'b0; cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk(!sdo_oe && !sdo, "R1/R9 released after select high", {sdo_oe, sdo}, 0);
  endtask

  task automatic begin_session(input int lead);
    logic o, e;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(!cfg_valid, "R3 cfg_valid cleared at session start", cfg_valid, 0);
    for (int i = 0; i < lead; i++) begin
      pulse(1'b0, o, e);
      chk(!e, "R2 low bits before start ignored", e, 0);
    end
    chk(!cfg_valid, "R2 no word before start", cfg_valid, 0);
    pulse(1'b1, o, e);
    chk(!e, "R4 released during start bit", e, 0);
  endtask

  task automatic session(input int lead, input logic [2:0] c, input logic [11:0] w, input int nread);
    logic o, e;
    sample = w;
    begin_session(lead);
    for (int i = 0; i < 3; i++) begin
      pulse(c[2-i], o, e);
      chk(!e, "R4 released during config bits", e, 0);
    end
    sample = 12'($urandom);
    chk(cfg == c && cfg_valid, "R3 config word", {cfg_valid, cfg}, {1'b1, c});
    pulse(1'($urandom), o, e);
    chk(e && !o, "R5 null bit", {e, o}, 2'b10);
    for (int k = 0; k < nread; k++) begin
      pulse(1'($urandom), o, e);
      if (k < 12) chk(e && o == exp_bit(w, k), "R6/R7 msb-first bit", {e, o}, {1'b1, exp_bit(w, k)});
      else        chk(e && o == exp_bit(w, k), "R8 lsb-first or zero tail", {e, o}, {1'b1, exp_bit(w, k)});
    end
    release_cs();
  endtask

  initial begin
    logic o, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdo_oe && !sdo && !cfg_valid, "R1 reset state", {sdo_oe, sdo, cfg_valid}, 0);

    session(40, 3'b101, 12'hA5C, 40);
    session(0, 3'b010, 12'h801, 30);
    session(1, 3'b111, 12'h000, 26);
    session(2, 3'b000, 12'hFFF, 26);

    // R9: abort during configuration, then a fresh session
    begin_session(2);
    pulse(1'b1, o, e);
    release_cs();
    chk(!cfg_valid, "R9 aborted word not valid", cfg_valid, 0);
    session(0, 3'b110, 12'h3C6, 24);

    // R9: abort during readout, then a fresh session
    session(1, 3'b011, 12'h5A5, 5);
    session(3, 3'b001, 12'h96E, 14);

    for (int s = 0; s < 6; s++)
      session(int'($urandom_range(0, 6)), 3'($urandom), 12'($urandom),
              int'($urandom_range(8, 32)));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule